// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

A free-running counter that either guards the system against a stalled program or produces a periodic tick. It advances on one of two count strobes, a fast system strobe or a slow auxiliary strobe, both produced outside the block. When the count reaches the length chosen by a two-bit tap field, one of two things happens. In watchdog mode the block pulses a reset request. In interval mode it sets a sticky interrupt flag instead. The interrupt request is that flag gated by an enable bit.

Software reaches the block over a simple register bus with three word addresses: control, flag and enable. Writes to the control word only take effect when the upper byte carries the key 0x5A. Any other key is treated as a fault and pulses the reset request at once. The control word can also restart the count from zero or freeze it.

Top module: `wdt_guard`

## Requirements
- R1: After reset, reading the control word (address 0) returns 0x6900, the flag, the enable, rst_req_o and irq_o are all 0, and the counter starts from zero in watchdog mode on the longest tap with the fast strobe.
- R2: A write to address 0 with 0x5A in bits 15:8 loads bits 7:0. A read of address 0 returns 0x69 in bits 15:8 and the stored low byte, with bit 3 always reading 0.
- R3: A write to address 0 whose bits 15:8 differ from 0x5A leaves the control word unchanged and drives rst_req_o high in the cycle after the write.
- R4: Control bits 1:0 set the period in counted strobes: 0 gives 32768, 1 gives 8192, 2 gives 512 and 3 gives 64.
- R5: Control bit 2 selects the count strobe: 0 counts fast_tick_i and 1 counts slow_tick_i. The strobe that is not selected has no effect.
- R6: A keyed write with bit 3 set restarts the count from zero at that write.
- R7: While control bit 7 is 1, the counter does not advance and no expiry occurs.
- R8: In watchdog mode (bit 4 = 0), expiry drives rst_req_o high for exactly one cycle, in the cycle after the expiring strobe.
- R9: In interval mode (bit 4 = 1), expiry sets the flag and does not raise rst_req_o. The flag stays set until software writes 0 to it. The counter wraps to zero and keeps its period.
- R10: Bit 0 of address 1 is the flag and bit 0 of address 2 is the enable, both readable and writable, with the other bits reading 0. irq_o is 1 exactly when both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_tick_i | input | 1 | Fast system count strobe |
| slow_tick_i | input | 1 | Slow auxiliary count strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 flag, 2 enable |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| rst_req_o | output | 1 | System reset request pulse |
| irq_o | output | 1 | Interrupt request |
| flag_o | output | 1 | Interrupt flag |
| ien_o | output | 1 | Interrupt enable |

## Verification
The assertions check several rules on every cycle. A clear command zeroes the counter, a hold freezes it, and an expiry wraps it. A rejected key leaves the control word untouched and raises the reset request next cycle. An interval-mode expiry never raises the reset request, and the flag only drops on an explicit write of 0. Other behaviour can only be shown by the bench scenarios. These are the exact period of each tap, the choice of count strobe, and the one-cycle width of the watchdog pulse. They also include the wrap that keeps the interval period after a late flag clear, and readback under random keyed and unkeyed writes.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam logic [7:0] RD_TAG = 8'h69;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_FLAG = 2'd1;
  localparam logic [1:0] A_IEN  = 2'd2;

  typedef struct packed {
    logic       hold;
    logic [1:0] spare;
    logic       interval;
    logic       clr;
    logic       slow_sel;
    logic [1:0] tap;
  } ctrl_t;
endpackage

// File: rtl/wdt_guard_regs.sv
module wdt_guard_regs
  import wdt_guard_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  output ctrl_t       ctrl_o,
  output logic        clr_o,
  output logic        bad_key_o
);
  ctrl_t ctrl_q;
  logic  key_ok;

  assign key_ok    = (wdata_i[15:8] == WR_KEY);
  assign bad_key_o = wr_i && !key_ok;
  assign clr_o     = wr_i && key_ok && wdata_i[3];
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i && key_ok) begin
      ctrl_q     <= ctrl_t'(wdata_i[7:0]);
      ctrl_q.clr <= 1'b0;  // command bit, never stored
    end
  end

  assert_badkey_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_key_o |=> $stable(ctrl_q));
endmodule

// File: rtl/wdt_guard_cnt.sv
module wdt_guard_cnt #(
  parameter int CNT_W = 16,
  parameter int TAP_LOG [4] = '{15, 13, 9, 6}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       clr_i,
  input  logic [1:0] tap_sel_i,
  output logic       expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tap_last [4];

  for (genvar g = 0; g < 4; g++) begin : g_tap
    assign tap_last[g] = CNT_W'((64'd1 << TAP_LOG[g]) - 64'd1);
  end

  // >= so that shrinking the tap mid-count still expires promptly
  assign expire_o = tick_i && !hold_i && !clr_i && (cnt_q >= tap_last[tap_sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i && !hold_i) cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clr_i) |=> $stable(cnt_q));
  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fast_tick_i,
  input  logic        slow_tick_i,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        rst_req_o,
  output logic        irq_o,
  output logic        flag_o,
  output logic        ien_o
);
  ctrl_t ctrl;
  logic  clr, bad_key, expire, tick;
  logic  flag_q, ien_q, rst_req_q;
  logic  wr_flag, wr_ien;

  assign wr_flag = wr_i && (addr_i == A_FLAG);
  assign wr_ien  = wr_i && (addr_i == A_IEN);
  assign tick    = ctrl.slow_sel ? slow_tick_i : fast_tick_i;

  wdt_guard_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i      (wr_i && (addr_i == A_CTRL)),
    .wdata_i,
    .ctrl_o    (ctrl),
    .clr_o     (clr),
    .bad_key_o (bad_key)
  );

  wdt_guard_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .hold_i    (ctrl.hold),
    .clr_i     (clr),
    .tap_sel_i (ctrl.tap),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= 1'b0;
      ien_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= bad_key || (expire && !ctrl.interval);
      if (expire && ctrl.interval) flag_q <= 1'b1;
      else if (wr_flag)            flag_q <= wdata_i[0];
      if (wr_ien) ien_q <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {RD_TAG, ctrl};
      A_FLAG:  rdata_o = {15'd0, flag_q};
      A_IEN:   rdata_o = {15'd0, ien_q};
      default: rdata_o = '0;
    endcase
  end

  assign rst_req_o = rst_req_q;
  assign flag_o    = flag_q;
  assign ien_o     = ien_q;
  assign irq_o     = flag_q && ien_q;

  assert_badkey_rst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_key |=> rst_req_o);
  assert_interval_noreset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ctrl.interval && !bad_key) |=> !rst_req_o);
  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !(wr_flag && !wdata_i[0])) |=> flag_o);
  assert_watchdog_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !ctrl.interval) |=> rst_req_o);
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fast_tick = 1'b1, slow_tick = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req, irq, flag, ien;
  int          n_chk = 0, n_fail = 0;
  int          slow_seen = 0;
  bit          slow_en = 1'b0;
  int          phase = 0;

  always #4 clk = ~clk;

  wdt_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rst_req_o(rst_req), .irq_o(irq), .flag_o(flag), .ien_o(ien));

  // slow strobe every 4th cycle when enabled; bench counts strobes seen at edges
  always @(negedge clk) begin
    phase = (phase + 1) % 4;
    slow_tick = slow_en && (phase == 0);
  end
  always @(posedge clk) if (slow_tick) slow_seen = slow_seen + 1;

  function automatic int tap_len(input logic [1:0] code);
    case (code)
      2'd0: return 32768;
      2'd1: return 8192;
      2'd2: return 512;
      default: return 64;
    endcase
  endfunction

  function automatic logic [15:0] exp_ctrl(input logic [7:0] lo);
    return {8'h69, lo & 8'hF7};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic read(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata; addr = 2'd0;
  endtask

  // edges after the last write until sig rises
  task automatic edges_until_flag(output int n);
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (!flag && n < 40000);
  endtask

  task automatic edges_until_rst(output int n);
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (!rst_req && n < 40000);
  endtask

  initial begin
    fork
      begin
        logic [15:0] d;
        int n;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        read(2'd0, d); check("R1 ctrl", d, 16'h6900);
        read(2'd1, d); check("R1 flag", d, 16'h0);
        read(2'd2, d); check("R1 ien", d, 16'h0);
        check("R1 rst_req/irq", {rst_req, irq}, 2'b00);

        // R8 watchdog expiry on tap 3, fast strobe
        write(2'd0, 16'h5A0B);
        edges_until_rst(n);
        check("R8 R4 period tap3 watchdog", n, 64);
        @(negedge clk);
        check("R8 pulse width", rst_req, 1'b0);
        check("R8 no flag in watchdog mode", flag, 1'b0);

        // R4 taps in interval mode
        for (int t = 3; t >= 0; t--) begin
          write(2'd0, 16'h5A88);
          write(2'd1, 16'h0000);
          write(2'd0, 16'h5A18 | 16'(t));
          edges_until_flag(n);
          check($sformatf("R4 R9 period tap%0d", t), n, tap_len(2'(t)));
          check("R9 no reset in interval", rst_req, 1'b0);
        end

        // R9 sticky flag and wrap: tap 3
        write(2'd0, 16'h5A88);
        write(2'd1, 16'h0000);
        write(2'd0, 16'h5A1B);
        edges_until_flag(n);
        repeat (10) @(negedge clk);
        check("R9 flag sticky", flag, 1'b1);
        write(2'd1, 16'h0000);
        check("R9 flag cleared by write", flag, 1'b0);
        edges_until_flag(n);
        check("R9 wrap keeps period", n, 53);

        // R7 hold
        write(2'd0, 16'h5A88);
        write(2'd1, 16'h0000);
        write(2'd0, 16'h5A9B);
        repeat (200) @(negedge clk);
        check("R7 hold stops count", {flag, rst_req}, 2'b00);
        write(2'd0, 16'h5A13);
        edges_until_flag(n);
        check("R7 resume from held count", n, 64);

        // R6 clear mid-count, tap 2
        write(2'd0, 16'h5A88);
        write(2'd1, 16'h0000);
        write(2'd0, 16'h5A1A);
        repeat (300) @(negedge clk);
        check("R6 not yet expired", flag, 1'b0);
        write(2'd0, 16'h5A1A);
        edges_until_flag(n);
        check("R6 clear restarts count", n, 512);

        // R5 slow strobe select, tap 3
        write(2'd0, 16'h5A88);
        write(2'd1, 16'h0000);
        slow_en = 1'b1;
        write(2'd0, 16'h5A1F);
        slow_seen = 0;
        edges_until_flag(n);
        check("R5 slow strobes counted", slow_seen, 64);
        check("R5 fast strobe ignored", n > 200, 1'b1);
        slow_en = 1'b0;

        // R10 irq gating
        write(2'd0, 16'h5A88);
        write(2'd2, 16'h0001);
        check("R10 irq flag&ien", irq, 1'b1);
        read(2'd2, d); check("R10 ien readback", d, 16'h0001);
        write(2'd1, 16'hFFFE);
        check("R10 irq drops with flag", irq, 1'b0);

        // random keyed and unkeyed writes, counter held
        for (int i = 0; i < 60; i++) begin
          logic [7:0] lo, key;
          logic [1:0] a;
          logic b;
          lo = 8'($urandom) | 8'h80;
          key = ($urandom % 2) ? 8'h5A : 8'($urandom);
          read(2'd0, d);
          write(2'd0, {key, lo});
          if (key == 8'h5A) begin
            check("R2 keyed write readback", rdata, exp_ctrl(lo));
            check("R2 no reset on keyed write", rst_req, 1'b0);
          end else begin
            check("R3 reset on bad key", rst_req, 1'b1);
            begin logic [15:0] d2; read(2'd0, d2); check("R3 ctrl kept", d2, d); end
          end
          a = ($urandom % 2) ? 2'd1 : 2'd2;
          b = 1'($urandom);
          write(a, {15'($urandom), b});
          read(a, d); check("R10 bit0 register readback", d, {15'd0, b});
          check("R10 irq gate", irq, flag & ien);
        end

        // R1 mid-run reset
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        read(2'd0, d); check("R1 ctrl after reset", d, 16'h6900);
        check("R1 outputs after reset", {rst_req, irq, flag, ien}, 4'b0);
      end
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule